// File: doc/BRIEF.md
# Test-Port Serial Access Master

This block drives the narrow configuration port of a receive PHY on behalf of a host. The port has a slow strobe clock, an enable line, an 8-bit write bus toward the PHY and an 8-bit read bus back from it. The host presents one request with a 12-bit register address, a direction flag and, for a write, one data byte. The block then walks the three port lines through a fixed list of single-change steps. The address goes out in three latched phases: a zero page byte, then the top address nibble, then the low address byte. A write follows with a data phase. A read instead captures the returned byte.

Every step is held for a number of system clocks given with the request, so the strobe stays inside the PHY's slow timing limits. A busy flag covers the whole transaction. A one-cycle done pulse ends it, and read data is presented at the same time. A separate clear line to the port follows its own control input and does not depend on the sequencer.

Top module: `tport_master`

## Requirements
- R1: After reset, tp_clk, tp_en, tp_din, tp_clr, busy, done and rd_data are all zero.
- R2: A request is accepted on a rising edge where req_valid is high and busy is low. busy is high from the next cycle until done. Requests presented while busy is high are ignored, and the running transaction keeps its own address, data and direction.
- R3: req_hold is captured at acceptance, and a value of 0 is treated as 1. The pin values of each step appear on the acceptance edge plus step×H, where H is the effective hold, and stay unchanged for exactly H cycles.
- R4: Steps 0 to 5 form the page phase. Step 0 drives tp_clk=0 and tp_en=0. Step 1 sets tp_en=1, step 2 sets tp_clk=1, step 3 sets tp_din=0x00, step 4 sets tp_clk=0 and step 5 sets tp_en=0. Each step changes only the line it names, and tp_din keeps its previous value in step 0.
- R5: In step 6, tp_din becomes address bits 11:8 zero-extended to 8 bits. In step 7, tp_clk goes to 1.
- R6: Steps 8 to 13 send the low address byte. Step 8 sets tp_clk=0, step 9 sets tp_en=1, step 10 sets tp_clk=1, step 11 sets tp_din to address bits 7:0, step 12 sets tp_clk=0 and step 13 sets tp_en=0. tp_en only ever changes while tp_clk is low.
- R7: A write (req_write=1) adds step 14, where tp_din becomes the data byte, and step 15, where tp_clk goes to 1. tp_clk is left high until the next transaction's step 0.
- R8: A read (req_write=0) has 14 steps. On the done edge, rd_data takes the value of tp_dout from the cycle before. rd_data changes at no other time, so a write leaves it unchanged.
- R9: done is a one-cycle pulse on the acceptance edge plus steps×H (16 steps for a write, 14 for a read). busy falls on the same edge, and a new request can be accepted in the done cycle.
- R10: tp_clr equals clr_in delayed by one clock, whatever the sequencer is doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 12 | Register address |
| req_wdata | input | 8 | Write data byte |
| req_hold | input | HOLD_W | System clocks per step (0 means 1) |
| clr_in | input | 1 | Control for the port clear line |
| tp_dout | input | 8 | Read bus from the PHY |
| tp_clk | output | 1 | Port strobe clock |
| tp_en | output | 1 | Port enable |
| tp_din | output | 8 | Write bus toward the PHY |
| tp_clr | output | 1 | Port clear line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| rd_data | output | 8 | Last read byte |

## Verification
Two things can happen in the same cycle: the done pulse of one transaction and the acceptance of the next request. The bench presents each new request in the very cycle done is seen, with nothing idle in between. It then checks that the new step 0 appears one edge later and pulls a strobe left high by a write back to low. The bench also raises a spurious request and toggles the clear control partway through transactions. It checks that neither one disturbs the step trace.

// File: rtl/tpm_pkg.sv
package tpm_pkg;
    localparam int TP_ADDR_W = 12;
    localparam int TP_DATA_W = 8;
    localparam int TP_STEPS  = 16;
    localparam int TP_STEP_W = $clog2(TP_STEPS);
    localparam int TP_HI_W   = TP_ADDR_W - TP_DATA_W;
    localparam logic [TP_STEP_W-1:0] LAST_WR_STEP = TP_STEP_W'(TP_STEPS - 1);
    localparam logic [TP_STEP_W-1:0] LAST_RD_STEP = TP_STEP_W'(TP_STEPS - 3);

    typedef struct packed {
        logic                 tclk;
        logic                 ten;
        logic [TP_DATA_W-1:0] tdin;
    } pins_t;
endpackage

// File: rtl/tpm_hold_timer.sv
module tpm_hold_timer #(
    parameter int HOLD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [HOLD_W-1:0] load_val,
    output logic              expire
);
    logic [HOLD_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val - HOLD_W'(1);
        else if (cnt_q != '0)
            cnt_d = cnt_q - HOLD_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == '0);

    // R3: an idle count keeps falling by one per cycle
    assert_count_down_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - HOLD_W'(1)));
endmodule

// File: rtl/tpm_step_rom.sv
module tpm_step_rom
    import tpm_pkg::*;
(
    input  logic [TP_STEP_W-1:0] step,
    input  logic [TP_ADDR_W-1:0] addr,
    input  logic [TP_DATA_W-1:0] wdata,
    input  pins_t                cur,
    output pins_t                nxt
);
    logic [TP_DATA_W-1:0] hi_byte;
    assign hi_byte = {{(TP_DATA_W-TP_HI_W){1'b0}}, addr[TP_ADDR_W-1:TP_DATA_W]};

    always_comb begin
        nxt = cur;
        case (step)
            4'd0:  begin nxt.tclk = 1'b0; nxt.ten = 1'b0; end
            4'd1:  nxt.ten  = 1'b1;
            4'd2:  nxt.tclk = 1'b1;
            4'd3:  nxt.tdin = '0;
            4'd4:  nxt.tclk = 1'b0;
            4'd5:  nxt.ten  = 1'b0;
            4'd6:  nxt.tdin = hi_byte;
            4'd7:  nxt.tclk = 1'b1;
            4'd8:  nxt.tclk = 1'b0;
            4'd9:  nxt.ten  = 1'b1;
            4'd10: nxt.tclk = 1'b1;
            4'd11: nxt.tdin = addr[TP_DATA_W-1:0];
            4'd12: nxt.tclk = 1'b0;
            4'd13: nxt.ten  = 1'b0;
            4'd14: nxt.tdin = wdata;
            default: nxt.tclk = 1'b1;
        endcase
    end
endmodule

// File: rtl/tpm_seq.sv
module tpm_seq
    import tpm_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [TP_ADDR_W-1:0] req_addr,
    input  logic [TP_DATA_W-1:0] req_wdata,
    input  logic [HOLD_W-1:0]    req_hold,
    input  logic [TP_DATA_W-1:0] tp_dout,
    input  logic                 expire,
    input  pins_t                rom_pins,
    output logic                 tmr_load,
    output logic [HOLD_W-1:0]    tmr_val,
    output logic [TP_STEP_W-1:0] rom_step,
    output logic [TP_ADDR_W-1:0] cur_addr,
    output logic [TP_DATA_W-1:0] cur_wdata,
    output pins_t                pins,
    output logic                 busy,
    output logic                 done,
    output logic [TP_DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic                 busy;
        logic                 done;
        logic                 write;
        logic [TP_STEP_W-1:0] step;
        logic [TP_ADDR_W-1:0] addr;
        logic [TP_DATA_W-1:0] wdata;
        logic [HOLD_W-1:0]    hold;
        pins_t                pins;
        logic [TP_DATA_W-1:0] rdata;
    } st_t;

    st_t st_d, st_q;
    logic [HOLD_W-1:0]    hold_eff;
    logic [TP_STEP_W-1:0] last_step;

    assign hold_eff  = (req_hold == '0) ? HOLD_W'(1) : req_hold;
    assign last_step = st_q.write ? LAST_WR_STEP : LAST_RD_STEP;
    assign rom_step  = st_q.step + TP_STEP_W'(1);

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        tmr_load  = 1'b0;
        tmr_val   = st_q.hold;
        if (!st_q.busy) begin
            if (req_valid) begin
                st_d.busy      = 1'b1;
                st_d.write     = req_write;
                st_d.addr      = req_addr;
                st_d.wdata     = req_wdata;
                st_d.hold      = hold_eff;
                st_d.step      = '0;
                st_d.pins.tclk = 1'b0;
                st_d.pins.ten  = 1'b0;
                tmr_load       = 1'b1;
                tmr_val        = hold_eff;
            end
        end else if (expire) begin
            if (st_q.step == last_step) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
                if (!st_q.write)
                    st_d.rdata = tp_dout;
            end else begin
                st_d.step = rom_step;
                st_d.pins = rom_pins;
                tmr_load  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cur_addr  = st_q.addr;
    assign cur_wdata = st_q.wdata;
    assign pins      = st_q.pins;
    assign busy      = st_q.busy;
    assign done      = st_q.done;
    assign rd_data   = st_q.rdata;

    // R2: a running transaction keeps its address
    assert_keep_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |=> (!st_q.busy || $stable(st_q.addr)));
    // R3: pins do not move while the hold timer is running
    assert_hold_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !expire) |=> $stable(st_q.pins));
    // R6: enable only moves while the strobe is low
    assert_en_clk_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.pins.ten) |-> !st_q.pins.tclk);
    // R8: read data changes only together with done
    assert_rdata_on_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(st_q.rdata) |-> st_q.done);
    // R9: done lasts one cycle
    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |=> !st_q.done);
    // R9: busy is low when done is seen
    assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> !st_q.busy);
endmodule

// File: rtl/tport_master.sv
module tport_master
    import tpm_pkg::*;
#(
    parameter int HOLD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [TP_ADDR_W-1:0] req_addr,
    input  logic [TP_DATA_W-1:0] req_wdata,
    input  logic [HOLD_W-1:0]    req_hold,
    input  logic                 clr_in,
    input  logic [TP_DATA_W-1:0] tp_dout,
    output logic                 tp_clk,
    output logic                 tp_en,
    output logic [TP_DATA_W-1:0] tp_din,
    output logic                 tp_clr,
    output logic                 busy,
    output logic                 done,
    output logic [TP_DATA_W-1:0] rd_data
);
    logic                 tmr_load, expire;
    logic [HOLD_W-1:0]    tmr_val;
    logic [TP_STEP_W-1:0] rom_step;
    logic [TP_ADDR_W-1:0] cur_addr;
    logic [TP_DATA_W-1:0] cur_wdata;
    pins_t                rom_pins, pins;
    logic                 clr_d, clr_q;

    tpm_seq #(.HOLD_W(HOLD_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_hold(req_hold),
        .tp_dout(tp_dout), .expire(expire), .rom_pins(rom_pins),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .rom_step(rom_step),
        .cur_addr(cur_addr), .cur_wdata(cur_wdata), .pins(pins),
        .busy(busy), .done(done), .rd_data(rd_data)
    );

    tpm_hold_timer #(.HOLD_W(HOLD_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .expire(expire)
    );

    tpm_step_rom u_rom (
        .step(rom_step), .addr(cur_addr), .wdata(cur_wdata), .cur(pins), .nxt(rom_pins)
    );

    assign clr_d = clr_in;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) clr_q <= 1'b0;
        else        clr_q <= clr_d;
    end

    assign tp_clk = pins.tclk;
    assign tp_en  = pins.ten;
    assign tp_din = pins.tdin;
    assign tp_clr = clr_q;

    // R10: clear line follows its control one clock later
    assert_clr_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (tp_clr == $past(clr_in)));
endmodule

// File: tb/tport_master_tb.sv
module tport_master_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HOLD_W = 8;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, clr_in = 1'b0;
    logic [11:0] req_addr = '0;
    logic [7:0]  req_wdata = '0, tp_dout = '0;
    logic [HOLD_W-1:0] req_hold = '0;
    logic tp_clk, tp_en, tp_clr, busy, done;
    logic [7:0] tp_din, rd_data;

    int checks = 0, failures = 0;
    bit finished = 0;
    logic [9:0] model = '0;
    logic [7:0] last_rd = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tport_master #(.HOLD_W(HOLD_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_hold(req_hold),
        .clr_in(clr_in), .tp_dout(tp_dout), .tp_clk(tp_clk), .tp_en(tp_en),
        .tp_din(tp_din), .tp_clr(tp_clr), .busy(busy), .done(done), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // expected pins {tclk, ten, tdin} after a step, from the step table
    function automatic logic [9:0] next_pins(input int s, input logic [9:0] cur,
                                             input logic [11:0] a, input logic [7:0] d);
        logic [9:0] n = cur;
        case (s)
            0:  begin n[9] = 1'b0; n[8] = 1'b0; end
            1, 9:  n[8] = 1'b1;
            5, 13: n[8] = 1'b0;
            2, 7, 10, 15: n[9] = 1'b1;
            4, 8, 12: n[9] = 1'b0;
            3:  n[7:0] = 8'h00;
            6:  n[7:0] = {4'h0, a[11:8]};
            11: n[7:0] = a[7:0];
            default: n[7:0] = d;
        endcase
        return n;
    endfunction

    function automatic string phase_tag(input int s);
        if (s <= 5) return "R4";
        if (s <= 7) return "R5";
        if (s <= 13) return "R6";
        return "R7";
    endfunction

    // called at a negedge; returns at the negedge of the done cycle
    task automatic run_txn(input bit wr, input logic [11:0] a, input logic [7:0] dt,
                           input logic [HOLD_W-1:0] h, input logic [7:0] dout,
                           input bit inject, input bit do_clr);
        int he = (h == 0) ? 1 : int'(h);
        int n = wr ? 16 : 14;
        logic [9:0] e [16];
        logic [9:0] cur = model;
        for (int s = 0; s < n; s++) begin
            cur = next_pins(s, cur, a, dt);
            e[s] = cur;
        end
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = dt;
        req_hold = h; tp_dout = dout;
        @(posedge clk);
        for (int c = 0; c <= n*he; c++) begin
            @(negedge clk);
            if (c == 0) req_valid = 1'b0;
            if (inject && c == 2) begin
                req_valid = 1'b1; req_addr = ~a; req_write = ~wr; req_wdata = ~dt; req_hold = 8'd1;
            end
            if (inject && c == 3) req_valid = 1'b0;
            if (c < n*he) begin
                int s = c / he;
                chk({tp_clk, tp_en, tp_din} == e[s],
                    (c % he == 0) ? phase_tag(s) : "R3", {tp_clk, tp_en, tp_din}, e[s]);
                chk(busy && !done, "R2", {busy, done}, 2'b10);
            end else begin
                chk(done && !busy, "R9", {busy, done}, 2'b01);
                chk(rd_data == (wr ? last_rd : dout), "R8", rd_data, wr ? last_rd : dout);
                if (wr) chk(tp_clk == 1'b1, "R7", tp_clk, 1'b1);
            end
            if (do_clr && c == 2) chk(tp_clr == clr_in, "R10", tp_clr, clr_in);
            if (do_clr && c == 1) clr_in = ~clr_in;
        end
        model = e[n-1];
        if (!wr) last_rd = dout;
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset values
        chk({tp_clk, tp_en, tp_din, tp_clr, busy, done, rd_data} == '0, "R1",
            {tp_clk, tp_en, tp_din, tp_clr, busy, done, rd_data}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done, "R1", {busy, done}, 0);
        // R10 while idle
        clr_in = 1'b1;
        @(negedge clk);
        chk(tp_clr == 1'b1, "R10", tp_clr, 1);
        clr_in = 1'b0;
        @(negedge clk);
        chk(tp_clr == 1'b0, "R10", tp_clr, 0);
        // directed corners
        run_txn(1'b1, 12'hFFF, 8'hA5, 8'd0, 8'h3C, 1'b0, 1'b0); // hold 0 -> 1
        run_txn(1'b0, 12'h123, 8'h00, 8'd1, 8'hC3, 1'b0, 1'b0); // strobe left high
        run_txn(1'b0, 12'h000, 8'h00, 8'd3, 8'h5A, 1'b1, 1'b1); // ignored request
        run_txn(1'b1, 12'h800, 8'hFF, 8'd2, 8'h99, 1'b1, 1'b1); // rdata kept
        // idle gap then random mix
        repeat (4) @(negedge clk);
        chk(!busy && !done, "R2", {busy, done}, 0);
        for (int i = 0; i < 30; i++) begin
            logic [HOLD_W-1:0] hh = HOLD_W'($urandom_range(0, 4));
            run_txn(1'($urandom), 12'($urandom), 8'($urandom), hh, 8'($urandom),
                    1'($urandom), 1'($urandom));
            if (($urandom & 3) == 0) repeat (1 + $urandom_range(0, 3)) @(negedge clk);
        end
        @(negedge clk);
        chk(!done, "R9", done, 0);
        summary();
    end
endmodule